// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with Data Inversion

This block moves one 8-bit word at a time over a clocked serial link. A host write of a byte starts a transfer. The byte goes out on the transmit line, one bit per transfer-clock period. At the same time, eight bits are captured from the receive line. When the eighth bit has been captured, the assembled byte is presented on the read port and a done flag is raised.

An optional inversion stage covers both directions. With it enabled, the written byte is complemented before it is shifted out, and the captured byte is complemented on its way to the read port.

The transfer clock has two sources:
- **Internal clock.** A programmable divider of the system clock produces it. The clock can be driven on a primary clock pin, or steered to either of two clock pins.
- **External clock.** An external clock is synchronized into the system clock domain and its edges advance the shift sequence. Both clock pins are released (output enables low).

Top module: `sync_serial_port`

## Requirements
- R1: When `cfgInvert` is 1 at the time of the write, every bit of the written byte is complemented before it appears on `txd`. When it is 0, bits go out unchanged.
- R2: `rdData` shows the last completed received byte, complemented bitwise when `cfgInvert` is 1 and unchanged when it is 0. In the line bit order, received bit j lands at the same byte position from which transmit bit j is taken.
- R3: A transfer carries exactly 8 bits. `busy` is 1 from the cycle after an accepted write until the sample edge of the eighth bit. At that edge `busy` drops and `done` rises. `done` clears on the next accepted write.
- R4: With `cfgClkPol` = 0, the clock idles high. Each bit is driven on `txd` at the falling edge, and `rxd` is captured at the following rising edge.
- R5: With `cfgClkPol` = 1, the clock idles low. Each bit is driven at the rising edge, and `rxd` is captured at the following falling edge.
- R6: With `cfgMsbFirst` = 0, bits travel in the order D0 first, D7 last. With 1, the order is D7 first, D0 last.
- R7: In internal-clock mode, each half period of the transfer clock lasts `cfgDiv`+1 system clocks, so a full period is 2·(`cfgDiv`+1). The first edge comes `cfgDiv`+1 cycles after the write is accepted.
- R8: In internal-clock mode, `clkPinA` carries the transfer clock when `cfgMultiPin` is 0, or when it is 1 and `cfgPinSel` is 0. `clkPinB` carries it when `cfgMultiPin` is 1 and `cfgPinSel` is 1. Both output enables are 1.
- R9: With `cfgExtClk` = 1, both clock-pin output enables are 0. The shift sequence follows edges of `extClkIn` after a two-flop synchronizer, with the same edge roles as R4 and R5.
- R10: Outside a transfer, `txd` is high. Whichever clock pin is not carrying the transfer clock is driven high.
- R11: A write while `busy` is 1 is ignored. The running transfer, its bits and its received byte are unaffected.
- R12: After reset: `txd` = 1, `busy` = 0, `done` = 0 and `rdData` = 0 (with `cfgInvert` = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Transmit-byte write strobe |
| wrData | input | 8 | Byte to transmit |
| rdData | output | 8 | Last received byte, after optional inversion |
| cfgInvert | input | 1 | 1 = invert data in both directions |
| cfgClkPol | input | 1 | 0 = drive on falling, sample on rising; 1 = swapped |
| cfgMsbFirst | input | 1 | 0 = LSB first, 1 = MSB first |
| cfgExtClk | input | 1 | 0 = internal transfer clock, 1 = external |
| cfgMultiPin | input | 1 | 1 = clock pin chosen by cfgPinSel |
| cfgPinSel | input | 1 | 0 = clkPinA, 1 = clkPinB (when cfgMultiPin = 1) |
| cfgDiv | input | 8 | Half-period length minus one, in system clocks |
| extClkIn | input | 1 | External transfer clock |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| clkPinA | output | 1 | First transfer-clock pin |
| clkPinAOe | output | 1 | Output enable of clkPinA |
| clkPinB | output | 1 | Second transfer-clock pin |
| clkPinBOe | output | 1 | Output enable of clkPinB |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer complete |

## Verification
If the phase counter or the divider count goes wrong, the clock pin toggles at the wrong cycle and the mismatch shows within one half period. A wrong bit index shows as a wrong `txd` value at the next drive edge. A fault in the receive assembly or the inversion stage shows only on `rdData` once `done` rises, so every transfer ends with a read-port check. The per-cycle model compares `txd`, both clock pins, their enables, `busy` and `done` on every clock. Steering, order or polarity errors are therefore caught at the first edge they affect.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // Strobes passed from the sequencer to the shift datapath
  typedef struct packed {
    logic load;    // accepted write: capture the byte, reset the bit index
    logic drive;   // drive edge: put the current bit on the line
    logic sample;  // sample edge: capture rxd, advance the index
    logic finish;  // last sample edge of the word
  } sspStrobe_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int BITS  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             cfgClkPol,
  input  logic             cfgExtClk,
  input  logic             cfgMultiPin,
  input  logic             cfgPinSel,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             extClkIn,
  output sspStrobe_t       strobe,
  output logic             busy,
  output logic             done,
  output logic             clkPinA,
  output logic             clkPinAOe,
  output logic             clkPinB,
  output logic             clkPinBOe
);
  localparam int EVENTS = 2 * BITS;
  localparam int PH_W   = $clog2(EVENTS);

  logic [DIV_W-1:0] divCnt;
  logic [PH_W-1:0]  phase;
  logic             away;
  logic [2:0]       extSync;
  logic             idleLevel, sclk, extEdge, extLead, extTrail, divTick, step, useB;

  assign idleLevel = ~cfgClkPol;
  assign sclk      = idleLevel ^ away;
  assign extEdge   = extSync[1] ^ extSync[2];
  assign extLead   = extEdge && (extSync[1] != idleLevel);
  assign extTrail  = extEdge && (extSync[1] == idleLevel);
  assign divTick   = (divCnt == cfgDiv);

  always_comb begin
    if (cfgExtClk) step = busy && (phase[0] ? extTrail : extLead);
    else           step = busy && divTick;
    strobe.load   = wrEn && !busy;
    strobe.drive  = step && !phase[0];
    strobe.sample = step && phase[0];
    strobe.finish = step && (phase == PH_W'(EVENTS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extSync <= '0;
    else       extSync <= {extSync[1:0], extClkIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      phase  <= '0;
      away   <= 1'b0;
      divCnt <= '0;
    end else if (strobe.load) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      phase  <= '0;
      away   <= 1'b0;
      divCnt <= '0;
    end else if (busy) begin
      divCnt <= divTick ? '0 : divCnt + 1'b1;
      if (step) begin
        away  <= ~away;
        phase <= phase + 1'b1;
      end
      if (strobe.finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // Clock-pin steering: the unused pin idles high; external mode releases both
  assign useB      = cfgMultiPin && cfgPinSel;
  assign clkPinA   = useB ? 1'b1 : sclk;
  assign clkPinB   = useB ? sclk : 1'b1;
  assign clkPinAOe = ~cfgExtClk;
  assign clkPinBOe = ~cfgExtClk;
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  sspStrobe_t      strobe,
  input  logic [BITS-1:0] wrData,
  input  logic            cfgInvert,
  input  logic            cfgMsbFirst,
  input  logic            rxd,
  output logic            txd,
  output logic [BITS-1:0] rdData
);
  localparam int IDX_W = $clog2(BITS);

  logic [BITS-1:0]  txByte, rxShift, rxHold, rxNext;
  logic [IDX_W-1:0] bitIdx, pos;

  assign pos = cfgMsbFirst ? (IDX_W'(BITS - 1) - bitIdx) : bitIdx;

  always_comb begin
    rxNext      = rxShift;
    rxNext[pos] = rxd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByte  <= '0;
      rxShift <= '0;
      rxHold  <= '0;
      bitIdx  <= '0;
      txd     <= 1'b1;
    end else begin
      if (strobe.load) begin
        txByte <= wrData ^ {BITS{cfgInvert}};
        bitIdx <= '0;
      end
      if (strobe.drive) txd <= txByte[pos];
      if (strobe.sample) begin
        rxShift <= rxNext;
        bitIdx  <= bitIdx + 1'b1;
      end
      if (strobe.finish) begin
        rxHold <= rxNext;
        txd    <= 1'b1;
      end
    end
  end

  assign rdData = rxHold ^ {BITS{cfgInvert}};
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int BITS  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [BITS-1:0]  wrData,
  output logic [BITS-1:0]  rdData,
  input  logic             cfgInvert,
  input  logic             cfgClkPol,
  input  logic             cfgMsbFirst,
  input  logic             cfgExtClk,
  input  logic             cfgMultiPin,
  input  logic             cfgPinSel,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             extClkIn,
  input  logic             rxd,
  output logic             txd,
  output logic             clkPinA,
  output logic             clkPinAOe,
  output logic             clkPinB,
  output logic             clkPinBOe,
  output logic             busy,
  output logic             done
);
  sspStrobe_t strobe;

  ssp_ctrl #(.DIV_W(DIV_W), .BITS(BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .cfgClkPol(cfgClkPol),
    .cfgExtClk(cfgExtClk), .cfgMultiPin(cfgMultiPin), .cfgPinSel(cfgPinSel),
    .cfgDiv(cfgDiv), .extClkIn(extClkIn), .strobe(strobe), .busy(busy),
    .done(done), .clkPinA(clkPinA), .clkPinAOe(clkPinAOe),
    .clkPinB(clkPinB), .clkPinBOe(clkPinBOe)
  );

  ssp_datapath #(.BITS(BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .cfgInvert(cfgInvert), .cfgMsbFirst(cfgMsbFirst), .rxd(rxd),
    .txd(txd), .rdData(rdData)
  );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic cfgExtClk,
  input logic cfgMultiPin,
  input logic cfgClkPol,
  input logic txd,
  input logic clkPinA,
  input logic clkPinAOe,
  input logic clkPinBOe,
  input logic busy,
  input logic done
);
  // R9: external clock releases both pins
  a_r9_pins_released: assert property (@(posedge clk) disable iff (!rstN)
    cfgExtClk |-> (!clkPinAOe && !clkPinBOe));

  // R10: transmit line idles high
  a_r10_txd_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txd);

  // R3: done rises only as busy ends
  a_r3_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(busy));

  // R3: a transfer only begins after a write
  a_r3_start_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn));

  // R4/R5: the primary pin rests at the idle level between transfers
  a_r4_r5_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cfgExtClk && !cfgMultiPin) |-> (clkPinA == !cfgClkPol));

  // R11: a write during a transfer never clears done or restarts early
  a_r11_busy_write: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> !done || !busy);
endmodule

bind sync_serial_port ssp_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .cfgExtClk(cfgExtClk),
  .cfgMultiPin(cfgMultiPin), .cfgClkPol(cfgClkPol), .txd(txd),
  .clkPinA(clkPinA), .clkPinAOe(clkPinAOe), .clkPinBOe(clkPinBOe),
  .busy(busy), .done(done)
);

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic cfgInvert = 1'b0, cfgClkPol = 1'b0, cfgMsbFirst = 1'b0, cfgExtClk = 1'b0;
  logic cfgMultiPin = 1'b0, cfgPinSel = 1'b0;
  logic [7:0] cfgDiv = '0;
  logic extClkIn = 1'b1, rxd = 1'b1;
  logic txd, clkPinA, clkPinAOe, clkPinB, clkPinBOe, busy, done;
  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sync_serial_port u_sync_serial_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .cfgInvert(cfgInvert), .cfgClkPol(cfgClkPol), .cfgMsbFirst(cfgMsbFirst),
    .cfgExtClk(cfgExtClk), .cfgMultiPin(cfgMultiPin), .cfgPinSel(cfgPinSel),
    .cfgDiv(cfgDiv), .extClkIn(extClkIn), .rxd(rxd), .txd(txd),
    .clkPinA(clkPinA), .clkPinAOe(clkPinAOe), .clkPinB(clkPinB),
    .clkPinBOe(clkPinBOe), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int posOf(input int j, input bit msb);
    return msb ? 7 - j : j;
  endfunction

  // Internal-clock transfer, compared every cycle against a behavioural model
  task automatic runXfer(input logic [7:0] tx, input logic [7:0] rx, input int n,
                         input bit inv, input bit pol, input bit msb,
                         input bit multi, input bit sel, input bit midWrite);
    int half = n + 1;
    logic [7:0] line = tx ^ {8{inv}};
    @(negedge clk);
    cfgExtClk = 0; cfgDiv = 8'(n); cfgInvert = inv; cfgClkPol = pol;
    cfgMsbFirst = msb; cfgMultiPin = multi; cfgPinSel = sel; rxd = 1;
    @(negedge clk);
    wrEn = 1; wrData = tx;
    @(negedge clk);
    wrEn = 0;
    for (int c = 0; c <= 16 * half + 2; c++) begin
      int e = c / half;
      bit expClk, useB, expTx;
      if (e > 16) e = 16;
      expClk = (!pol) ^ e[0];
      useB = multi && sel;
      expTx = (e == 0 || e >= 16) ? 1'b1 : line[posOf((e - 1) / 2, msb)];
      check("R1/R4/R5/R6 txd", 32'(txd), 32'(expTx));
      check("R7/R8 clkPinA", 32'(clkPinA), useB ? 32'd1 : 32'(expClk));
      check("R8/R10 clkPinB", 32'(clkPinB), useB ? 32'(expClk) : 32'd1);
      check("R8 oe", {clkPinAOe, clkPinBOe}, 32'd3);
      check("R3 busy", 32'(busy), 32'(e < 16));
      check("R3 done", 32'(done), 32'(e >= 16));
      if (e[0] && e < 16) rxd = rx[posOf((e - 1) / 2, msb)];
      if (midWrite && c == 3) begin wrEn = 1; wrData = ~tx; end
      else wrEn = 0;
      @(negedge clk);
    end
    wrEn = 0;
    check("R2/R11 rdData", 32'(rdData), 32'(rx ^ {8{inv}}));
  endtask

  // External-clock transfer: sampled in settled windows after each edge
  task automatic runExt(input logic [7:0] tx, input logic [7:0] rx,
                        input bit inv, input bit pol, input bit msb);
    logic [7:0] line = tx ^ {8{inv}};
    @(negedge clk);
    cfgExtClk = 1; cfgInvert = inv; cfgClkPol = pol; cfgMsbFirst = msb;
    cfgMultiPin = 1; cfgDiv = 8'd0; extClkIn = !pol;
    repeat (4) @(negedge clk);
    wrEn = 1; wrData = tx;
    @(negedge clk);
    wrEn = 0;
    check("R9 oe released", {clkPinAOe, clkPinBOe}, 32'd0);
    repeat (6) @(negedge clk);
    check("R9 no edge no drive", 32'(txd), 32'd1);
    for (int k = 0; k < 16; k++) begin
      extClkIn = ~extClkIn;
      repeat (8) @(negedge clk);
      if (k % 2 == 0) begin
        check("R9 txd", 32'(txd), 32'(line[posOf(k / 2, msb)]));
        rxd = rx[posOf(k / 2, msb)];
      end else if (k < 15) begin
        check("R9 busy", 32'(busy), 32'd1);
      end
    end
    check("R9 done", 32'(done), 32'd1);
    check("R9/R2 rdData", 32'(rdData), 32'(rx ^ {8{inv}}));
    check("R10 txd idle", 32'(txd), 32'd1);
    cfgExtClk = 0; cfgMultiPin = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12 txd", 32'(txd), 32'd1);
    check("R12 busy", 32'(busy), 32'd0);
    check("R12 done", 32'(done), 32'd0);
    check("R12 rdData", 32'(rdData), 32'd0);
    rstN = 1;
    repeat (2) @(negedge clk);
    runXfer(8'hA5, 8'h3C, 2, 0, 0, 0, 0, 0, 0);
    runXfer(8'hA5, 8'h3C, 2, 1, 0, 0, 0, 0, 0);
    runXfer(8'h1E, 8'hC3, 1, 0, 1, 1, 0, 0, 0);
    runXfer(8'h80, 8'h01, 0, 1, 1, 0, 0, 0, 0);
    runXfer(8'h5A, 8'h96, 3, 0, 0, 1, 1, 0, 0);
    runXfer(8'hF0, 8'h0F, 1, 0, 1, 0, 1, 1, 0);
    runXfer(8'h69, 8'hE7, 4, 0, 0, 0, 0, 0, 1);
    runExt(8'hB2, 8'h4D, 1, 0, 0);
    runExt(8'h2B, 8'hD4, 0, 1, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule